// File: doc/BRIEF.md
# Recency-Ordered Translation Buffer with Domain and Cacheability Checks

This block is a small, fully associative address translation cache. Each entry holds a virtual page number, a context tag, a physical frame number, a domain number, a non-cacheable mark and a set of memory attribute bits. A lookup compares the request's page and context against every entry in parallel. In the same cycle it returns the physical address, the attributes, a fault code and the request flags for uncacheable and clear-exclusive handling.

Entries are stored in recency order. Slot 0 holds the newest entry. A fill always enters at slot 0 and pushes the rest down by one, so the last slot is dropped. A hit deeper than the first two slots is pulled to the front. A normal miss parks the request and asks an external walker for the entry. Once the walker supplies the fill, the parked request is looked up again and answered. A miss on a prefetch is answered at once with an abort code.

Top module: `mtf_tlb`

## Requirements
- R1: An entry hits only when it is valid and both its virtual page number (`req_va[31:12]`) and its context tag equal those of the request. When several entries match, the lowest slot wins.
- R2: A hit answers combinationally in the cycle of the request, with `resp_valid`=1, `resp_pa` = {frame number, `req_va[11:0]`} and `resp_attr` = the entry's attribute bits.
- R3: A hit at slot 2 or deeper moves that entry to slot 0 at the next clock edge, and slots 0 up to the old slot minus one each move down by one. A hit at slot 0 or 1 leaves the order as it is.
- R4: `fill_valid` inserts the supplied entry at slot 0 at the next edge. Every other entry moves down by one and the entry in the last slot is lost. A flush in the same cycle wins over a fill, and a fill wins over a reorder.
- R5: A miss on a request with `req_prefetch`=0 gives no response. From the next edge, `walk_req`=1 with `walk_va`/`walk_ctx` holding the request, and `req_ready`=0. This holds until `fill_valid`. In the cycle after the fill, the parked request is answered through the response ports. `req_ready` returns to 1 one cycle later.
- R6: A miss with `req_prefetch`=1 answers at once with `resp_valid`=1, `resp_fault`=2 (prefetch abort) and `resp_pa`=0. It never raises `walk_req` and never changes the table.
- R7: A request with `req_clrex`=1 skips the lookup and answers in the same cycle with `resp_pa`=0, `resp_uncache`=1, `resp_clrex`=1 and `resp_fault`=0.
- R8: A hit sets `resp_uncache` when the relevant cache enable is 0: `icache_en` for `req_fetch`=1, `dcache_en` otherwise.
- R9: A hit on an entry whose non-cacheable mark is 1 sets `resp_uncache` whatever the enables are.
- R10: On a hit, the access type is `dacr[2*d+1:2*d]`, where d is the entry's domain. Values 0 (no access) and 2 (reserved) give `resp_fault`=1. Values 1 (client) and 3 (manager) give `resp_fault`=0.
- R11: `flush` clears the valid bit of every entry at the next edge, so every later lookup misses until the next fill.
- R12: After reset the table is empty, `req_ready`=1, and `resp_valid` and `walk_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block idle and taking requests |
| req_va | input | 32 | Request virtual address |
| req_ctx | input | 8 | Request context tag |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_prefetch | input | 1 | Request is a prefetch |
| req_clrex | input | 1 | Request is a clear-exclusive |
| icache_en | input | 1 | Instruction cache enable |
| dcache_en | input | 1 | Data cache enable |
| dacr | input | 32 | Domain access control, 2 bits per domain |
| resp_valid | output | 1 | Response present |
| resp_pa | output | 32 | Translated physical address |
| resp_attr | output | 4 | Memory attribute bits of the hit entry |
| resp_fault | output | 2 | 0 none, 1 domain fault, 2 prefetch abort |
| resp_uncache | output | 1 | Access must be uncacheable |
| resp_clrex | output | 1 | Clear-exclusive flag |
| walk_req | output | 1 | Walk requested for a parked miss |
| walk_va | output | 32 | Virtual address to walk |
| walk_ctx | output | 8 | Context tag to walk |
| fill_valid | input | 1 | Insert entry at slot 0 |
| fill_vpn | input | 20 | Fill virtual page number |
| fill_ctx | input | 8 | Fill context tag |
| fill_pfn | input | 20 | Fill physical frame number |
| fill_domain | input | 4 | Fill domain number |
| fill_nc | input | 1 | Fill non-cacheable mark |
| fill_attr | input | 4 | Fill attribute bits |
| flush | input | 1 | Invalidate all entries |

## Verification
Hit, prefetch-abort and clear-exclusive responses are combinational. The bench drives each request just after a falling edge and samples one time unit later, before the rising edge. Table changes (fills, flushes, move-to-front) show only from the next rising edge on. So recency is never read directly: the bench proves the order by filling just enough entries to push out a chosen one, then probing it with a prefetch, which hits or aborts without changing the table. On a walk, `walk_req` is sampled after the edge that parks the miss. The replayed answer is sampled after the edge that takes the fill, and `req_ready` one edge later.

// File: rtl/mtf_tlb.sv
module mtf_tlb #(
  parameter int ENTRIES    = 8,
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int CTX_W      = 8,
  parameter int PAGE_SHIFT = 12,
  parameter int DOM_W      = 4,
  parameter int ATTR_W     = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [VA_W-1:0]              req_va,
  input  logic [CTX_W-1:0]             req_ctx,
  input  logic                         req_fetch,
  input  logic                         req_prefetch,
  input  logic                         req_clrex,
  input  logic                         icache_en,
  input  logic                         dcache_en,
  input  logic [(2<<DOM_W)-1:0]        dacr,
  output logic                         resp_valid,
  output logic [PA_W-1:0]              resp_pa,
  output logic [ATTR_W-1:0]            resp_attr,
  output logic [1:0]                   resp_fault,
  output logic                         resp_uncache,
  output logic                         resp_clrex,
  output logic                         walk_req,
  output logic [VA_W-1:0]              walk_va,
  output logic [CTX_W-1:0]             walk_ctx,
  input  logic                         fill_valid,
  input  logic [VA_W-PAGE_SHIFT-1:0]   fill_vpn,
  input  logic [CTX_W-1:0]             fill_ctx,
  input  logic [PA_W-PAGE_SHIFT-1:0]   fill_pfn,
  input  logic [DOM_W-1:0]             fill_domain,
  input  logic                         fill_nc,
  input  logic [ATTR_W-1:0]            fill_attr,
  input  logic                         flush
);
  localparam int VPN_W = VA_W - PAGE_SHIFT;
  localparam int PFN_W = PA_W - PAGE_SHIFT;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  typedef struct packed {
    logic              v;
    logic [VPN_W-1:0]  vpn;
    logic [CTX_W-1:0]  ctx;
    logic [PFN_W-1:0]  pfn;
    logic [DOM_W-1:0]  dom;
    logic              nc;
    logic [ATTR_W-1:0] attr;
  } ent_t;

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_REPLAY} st_t;

  st_t               st_q;
  ent_t              tbl_q [ENTRIES];
  ent_t              tbl_d [ENTRIES];
  logic [VA_W-1:0]   pend_va;
  logic [CTX_W-1:0]  pend_ctx;
  logic              pend_fetch;

  logic              idle_req, replay, clrex_go, lk_go;
  logic [VA_W-1:0]   lk_va;
  logic [CTX_W-1:0]  lk_ctx;
  logic              lk_fetch;
  logic [ENTRIES-1:0] match;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  ent_t              h;
  logic [1:0]        dom_acc;
  logic              cache_en;

  assign idle_req = (st_q == S_IDLE) && req_valid;
  assign replay   = (st_q == S_REPLAY);
  assign clrex_go = idle_req && req_clrex;
  assign lk_go    = (idle_req && !req_clrex) || replay;

  assign lk_va    = replay ? pend_va    : req_va;
  assign lk_ctx   = replay ? pend_ctx   : req_ctx;
  assign lk_fetch = replay ? pend_fetch : req_fetch;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = tbl_q[g].v && (tbl_q[g].vpn == lk_va[VA_W-1:PAGE_SHIFT])
                      && (tbl_q[g].ctx == lk_ctx);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign h        = tbl_q[hit_idx];
  assign dom_acc  = dacr[int'(h.dom)*2 +: 2];
  assign cache_en = lk_fetch ? icache_en : dcache_en;

  assign req_ready    = (st_q == S_IDLE);
  assign walk_req     = (st_q == S_WALK);
  assign walk_va      = pend_va;
  assign walk_ctx     = pend_ctx;

  assign resp_valid   = clrex_go || (lk_go && (hit || (idle_req && req_prefetch)));
  assign resp_pa      = (lk_go && hit) ? {h.pfn, lk_va[PAGE_SHIFT-1:0]} : '0;
  assign resp_attr    = (lk_go && hit) ? h.attr : '0;
  assign resp_clrex   = clrex_go;
  assign resp_uncache = clrex_go || (lk_go && hit && (!cache_en || h.nc));

  always_comb begin
    resp_fault = 2'd0;
    if (lk_go && hit)                             resp_fault = dom_acc[0] ? 2'd0 : 2'd1;
    else if (idle_req && !req_clrex && req_prefetch) resp_fault = 2'd2;
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) tbl_d[i] = tbl_q[i];
    if (flush) begin
      for (int i = 0; i < ENTRIES; i++) tbl_d[i].v = 1'b0;
    end else if (fill_valid) begin
      for (int i = 1; i < ENTRIES; i++) tbl_d[i] = tbl_q[i-1];
      tbl_d[0] = '{v: 1'b1, vpn: fill_vpn, ctx: fill_ctx, pfn: fill_pfn,
                   dom: fill_domain, nc: fill_nc, attr: fill_attr};
    end else if (lk_go && hit && (hit_idx > IDX_W'(1))) begin
      for (int i = 1; i < ENTRIES; i++)
        if (IDX_W'(i) <= hit_idx) tbl_d[i] = tbl_q[i-1];
      tbl_d[0] = h;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= tbl_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      pend_va    <= '0;
      pend_ctx   <= '0;
      pend_fetch <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (lk_go && !hit && !req_prefetch) begin
          st_q       <= S_WALK;
          pend_va    <= req_va;
          pend_ctx   <= req_ctx;
          pend_fetch <= req_fetch;
        end
        S_WALK:   if (fill_valid) st_q <= S_REPLAY;
        S_REPLAY: st_q <= hit ? S_IDLE : S_WALK;
        default:  st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mtf_tlb_chk.sv
module mtf_tlb_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_prefetch,
  input logic            req_clrex,
  input logic            resp_valid,
  input logic [PA_W-1:0] resp_pa,
  input logic [1:0]      resp_fault,
  input logic            resp_uncache,
  input logic            resp_clrex,
  input logic            walk_req,
  input logic            fill_valid,
  input logic            flush
);
  // R5
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && !fill_valid |=> walk_req);

  // R5
  walk_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> !req_ready && !resp_valid);

  // R6
  pf_no_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(walk_req) && $past(req_ready) |-> $past(!req_prefetch && !req_clrex));

  // R7
  clrex_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && req_valid && req_clrex |->
      resp_valid && resp_pa == '0 && resp_uncache && resp_clrex && resp_fault == 2'd0);

  // R11
  flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) && req_ready && req_valid && !req_clrex |->
      !resp_valid || resp_fault == 2'd2);
endmodule

bind mtf_tlb mtf_tlb_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_prefetch(req_prefetch), .req_clrex(req_clrex), .resp_valid(resp_valid),
  .resp_pa(resp_pa), .resp_fault(resp_fault), .resp_uncache(resp_uncache),
  .resp_clrex(resp_clrex), .walk_req(walk_req), .fill_valid(fill_valid),
  .flush(flush));

// File: tb/mtf_tlb_bench.sv
module mtf_tlb_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_fetch = 0, req_prefetch = 0, req_clrex = 0;
  logic [31:0] req_va = '0;
  logic [7:0]  req_ctx = '0;
  logic        icache_en = 1, dcache_en = 1;
  logic [31:0] dacr = 32'h5555_5555;
  logic        req_ready, resp_valid, resp_uncache, resp_clrex, walk_req;
  logic [31:0] resp_pa, walk_va;
  logic [3:0]  resp_attr;
  logic [1:0]  resp_fault;
  logic [7:0]  walk_ctx;
  logic        fill_valid = 0, fill_nc = 0, flush = 0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic [7:0]  fill_ctx = '0;
  logic [3:0]  fill_domain = '0, fill_attr = '0;

  int total = 0, bad = 0;
  logic        c_valid, c_unc, c_clx;
  logic [31:0] c_pa;
  logic [1:0]  c_fault;
  logic [3:0]  c_attr;

  always #(CLK_P/2) clk = ~clk;

  mtf_tlb u_mtf_tlb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_ctx(req_ctx), .req_fetch(req_fetch),
    .req_prefetch(req_prefetch), .req_clrex(req_clrex), .icache_en(icache_en),
    .dcache_en(dcache_en), .dacr(dacr), .resp_valid(resp_valid), .resp_pa(resp_pa),
    .resp_attr(resp_attr), .resp_fault(resp_fault), .resp_uncache(resp_uncache),
    .resp_clrex(resp_clrex), .walk_req(walk_req), .walk_va(walk_va),
    .walk_ctx(walk_ctx), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_ctx(fill_ctx), .fill_pfn(fill_pfn), .fill_domain(fill_domain),
    .fill_nc(fill_nc), .fill_attr(fill_attr), .flush(flush));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [19:0] vpn, input logic [7:0] ctx, input logic [19:0] pfn,
                      input logic [3:0] dom, input logic nc, input logic [3:0] attr);
    @(negedge clk);
    fill_vpn = vpn; fill_ctx = ctx; fill_pfn = pfn; fill_domain = dom;
    fill_nc = nc; fill_attr = attr; fill_valid = 1;
    @(posedge clk); #1 fill_valid = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(posedge clk); #1 flush = 0;
  endtask

  task automatic probe(input logic [31:0] va, input logic [7:0] ctx, input logic fetch,
                       input logic pf, input logic clx);
    @(negedge clk);
    req_va = va; req_ctx = ctx; req_fetch = fetch; req_prefetch = pf;
    req_clrex = clx; req_valid = 1;
    #1;
    c_valid = resp_valid; c_pa = resp_pa; c_fault = resp_fault;
    c_unc = resp_uncache; c_clx = resp_clrex; c_attr = resp_attr;
    @(posedge clk); #1 req_valid = 0; req_prefetch = 0; req_clrex = 0;
  endtask

  task automatic t_reset();
    #1;
    chk("R12 ready", req_ready, 1);
    chk("R12 resp_valid", resp_valid, 0);
    chk("R12 walk_req", walk_req, 0);
    probe(32'h0000_7000, 8'd0, 0, 1, 0);
    chk("R12 empty table aborts prefetch", c_fault, 2);
  endtask

  task automatic t_walk();
    probe(32'h0001_2345, 8'd3, 0, 0, 0);
    chk("R5 miss no response", c_valid, 0);
    chk("R5 walk_req", walk_req, 1);
    chk("R5 walk_va", walk_va, 32'h0001_2345);
    chk("R5 walk_ctx", walk_ctx, 3);
    chk("R5 ready low", req_ready, 0);
    repeat (2) @(posedge clk);
    #1 chk("R5 walk held", walk_req, 1);
    @(negedge clk);
    fill_vpn = 20'h00012; fill_ctx = 8'd3; fill_pfn = 20'h00ABC; fill_domain = 4'd1;
    fill_nc = 0; fill_attr = 4'h5; fill_valid = 1;
    #1 chk("R5 no response in fill cycle", resp_valid, 0);
    @(posedge clk); #1 fill_valid = 0;
    chk("R5 replay valid", resp_valid, 1);
    chk("R2 replay pa", resp_pa, 32'h00AB_C345);
    chk("R2 replay attr", resp_attr, 5);
    chk("R5 replay fault", resp_fault, 0);
    @(posedge clk); #1;
    chk("R5 ready back", req_ready, 1);
    chk("R5 walk dropped", walk_req, 0);
  endtask

  task automatic t_match();
    probe(32'h0001_2FFF, 8'd3, 0, 1, 0);
    chk("R1 hit valid", c_valid, 1);
    chk("R2 pa low bits", c_pa, 32'h00AB_CFFF);
    chk("R1 hit no fault", c_fault, 0);
    probe(32'h0001_2345, 8'd4, 0, 1, 0);
    chk("R1 ctx mismatch aborts", c_fault, 2);
    chk("R6 abort pa zero", c_pa, 0);
    chk("R6 no walk", walk_req, 0);
    probe(32'h0001_3345, 8'd3, 0, 1, 0);
    chk("R1 vpn mismatch aborts", c_fault, 2);
    chk("R6 abort valid", c_valid, 1);
  endtask

  task automatic t_clrex();
    probe(32'h0001_2345, 8'd3, 0, 0, 1);
    chk("R7 valid", c_valid, 1);
    chk("R7 pa zero", c_pa, 0);
    chk("R7 uncache", c_unc, 1);
    chk("R7 clrex", c_clx, 1);
    chk("R7 fault", c_fault, 0);
    chk("R7 no walk", walk_req, 0);
  endtask

  task automatic t_uncache();
    load(20'h00060, 8'd2, 20'h00160, 4'd0, 0, 4'h1);
    load(20'h00061, 8'd2, 20'h00161, 4'd0, 1, 4'h2);
    icache_en = 0; dcache_en = 1;
    probe(32'h0006_0000, 8'd2, 1, 0, 0);
    chk("R8 fetch icache off", c_unc, 1);
    probe(32'h0006_0000, 8'd2, 0, 0, 0);
    chk("R8 data dcache on", c_unc, 0);
    icache_en = 1; dcache_en = 0;
    probe(32'h0006_0000, 8'd2, 1, 0, 0);
    chk("R8 fetch icache on", c_unc, 0);
    probe(32'h0006_0000, 8'd2, 0, 0, 0);
    chk("R8 data dcache off", c_unc, 1);
    dcache_en = 1;
    probe(32'h0006_1000, 8'd2, 0, 0, 0);
    chk("R9 nc entry", c_unc, 1);
    chk("R9 attr", c_attr, 2);
  endtask

  task automatic t_domain();
    load(20'h00050, 8'd9, 20'h00150, 4'd5, 0, 4'h0);
    for (int a = 0; a < 4; a++) begin
      dacr = 32'(a) << 10;
      probe(32'h0005_0010, 8'd9, 0, 0, 0);
      chk("R10 domain verdict", c_fault, (a == 0 || a == 2) ? 2'd1 : 2'd0);
      chk("R10 valid", c_valid, 1);
    end
    dacr = 32'h5555_5555;
  endtask

  task automatic t_flush();
    load(20'h00070, 8'd1, 20'h00170, 4'd0, 0, 4'h0);
    do_flush();
    probe(32'h0007_0000, 8'd1, 0, 1, 0);
    chk("R11 flushed entry misses", c_fault, 2);
    probe(32'h0006_0000, 8'd2, 0, 1, 0);
    chk("R11 older entry misses", c_fault, 2);
  endtask

  task automatic t_mtf();
    do_flush();
    for (int k = 1; k <= 9; k++) load(20'h100 + 20'(k), 8'd1, 20'h200 + 20'(k), 4'd0, 0, 4'h0);
    probe(32'h0010_1000, 8'd1, 0, 1, 0);
    chk("R4 tail evicted", c_fault, 2);
    probe(32'h0010_2000, 8'd1, 0, 0, 0);
    chk("R3 deep hit pa", c_pa, 32'h0020_2000);
    load(20'h10A, 8'd1, 20'h20A, 4'd0, 0, 4'h0);
    probe(32'h0010_2000, 8'd1, 0, 1, 0);
    chk("R3 moved entry survives", c_fault, 0);
    probe(32'h0010_3000, 8'd1, 0, 1, 0);
    chk("R3 next tail evicted", c_fault, 2);
  endtask

  task automatic t_protect();
    do_flush();
    for (int k = 1; k <= 8; k++) load(20'h100 + 20'(k), 8'd1, 20'h200 + 20'(k), 4'd0, 0, 4'h0);
    probe(32'h0010_7000, 8'd1, 0, 0, 0);
    chk("R3 slot1 hit", c_fault, 0);
    for (int k = 11; k <= 17; k++) load(20'h100 + 20'(k), 8'd1, 20'h200 + 20'(k), 4'd0, 0, 4'h0);
    probe(32'h0010_7000, 8'd1, 0, 1, 0);
    chk("R3 slot1 hit did not move", c_fault, 2);
    probe(32'h0010_8000, 8'd1, 0, 1, 0);
    chk("R4 slot0 entry now at tail", c_fault, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_walk();
    t_match();
    t_clrex();
    t_uncache();
    t_domain();
    t_flush();
    t_mtf();
    t_protect();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule